// File: doc/BRIEF.md
# Hash Message Sequencer

This block sits in front of the round logic of a 256-bit sponge-style hash (a belt buffer plus a state transform). It takes a stream of 32-bit message words on a valid/ready handshake and packs them into eight-word blocks. Each full block goes to the core as one push step. When a word arrives with the last flag, the sequencer pads the message and issues the closing push. It then runs the blank pull steps and captures the digest from the core's state.

A start pulse clears the core and the sequencer's own word count and buffer. The core takes one step on every clock cycle in which `core_step` is high. In that cycle, `core_pull` selects pull mode (high) or push mode (low), and `core_block` carries the message block in push mode. The core returns state words 9 to 16 on `core_state_hi`. The sequencer latches them into `digest` and pulses `done` for one cycle. The digest stays unchanged until the next start.

The controller is an enumerated state machine with these states:
- `ST_IDLE`: after reset.
- `ST_FILL`: accepting words.
- `ST_PUSH`: pushing a full block.
- `ST_FINAL`: the padded push.
- `ST_PULL`: the blank steps.
- `ST_CAPTURE`: latching the digest.
- `ST_HOLD`: presenting the digest.

Its transitions are:
- start from any state goes to `ST_FILL`.
- `ST_FILL` goes to `ST_PUSH` on the word that fills slot 7.
- `ST_FILL` goes to `ST_FINAL` on a last word in slot 0 to 6.
- `ST_PUSH` goes to `ST_FINAL` if that block held the last word, otherwise back to `ST_FILL`.
- `ST_FINAL` goes to `ST_PULL`.
- `ST_PULL` goes to `ST_CAPTURE` after its 32nd step.
- `ST_CAPTURE` goes to `ST_HOLD`.

Top module: `hash_msg_sequencer`

## Requirements
- R1: Reset behaviour:
  - After reset, `in_ready`, `core_step`, `core_pull` and `done` are low and `digest` is zero.
  - This holds until a start pulse arrives.
- R2: Start behaviour:
  - A start pulse drives `core_clear` high in the same cycle, with no step in that cycle.
  - From the next cycle, `in_ready` is high.
  - Words accepted before the start are discarded, so the next block contains only words accepted after it.
- R3: Accepted words fill block slots in arrival order, with slot j at `core_block[32j+31:32j]`. Each eighth word is followed by exactly one push step (`core_step` high, `core_pull` low) carrying that block.
- R4: Padding inside a block: when the last word lands in slot s < 7, the closing push carries that word in slot s, the value 1 in slot s+1, and zero in every higher slot.
- R5: Padding on a block boundary: when the last word lands in slot 7, that block is pushed first. A second push follows, carrying 1 in slot 0 and zero in slots 1 to 7.
- R6: After the closing push, the sequencer issues exactly 32 consecutive steps with `core_pull` high, and no push steps.
- R7: Digest capture:
  - The cycle after the final pull step, `digest` takes the value of `core_state_hi` (state word 9 in bits 31:0, word 16 in bits 255:224).
  - In the cycle after that, `done` is high for exactly one cycle.
- R8: Input is refused while work is pending:
  - `in_ready` is low during every step cycle and from the completion of the message until the next start.
  - Words offered while `in_ready` is low have no effect on any later block.
- R9: Digest hold:
  - Between `done` and the next start, `digest` does not change.
  - A start clears `digest` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new message; clears core and sequencer |
| in_valid | input | 1 | Message word offered |
| in_ready | output | 1 | Message word can be taken this cycle |
| in_data | input | 32 | Message word |
| in_last | input | 1 | Offered word is the final word of the message |
| core_clear | output | 1 | Zero the core state and belt |
| core_step | output | 1 | Core performs one step this cycle |
| core_pull | output | 1 | Step mode: 1 = pull (blank), 0 = push |
| core_block | output | 256 | Eight-word block for a push step |
| core_state_hi | input | 256 | Core state words 9..16, word 9 lowest |
| digest | output | 256 | Captured hash value |
| done | output | 1 | One-cycle pulse when digest becomes valid |

## Verification
Two kinds of faults show up at the ports. A wrong word count or a wrong slot pointer shows in the `core_block` of the first push after the fault, at most eight accepted words later. A lost closing flag shows as a missing padding block at the end of the message.

A wrong pull counter shows in the number of `core_pull` cycles and in the delay to `done`, within about 40 cycles of the last word. A state machine stuck in a busy state shows as `in_ready` staying low after a start.

The bench tallies push and pull steps for every message and compares each pushed block word by word. It checks the padding positions for messages that end inside a block and on a block boundary. It also confirms that words offered while `in_ready` is low never appear in any block.

// File: rtl/hms_pkg.sv
package hms_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_PUSH,
        ST_FINAL,
        ST_PULL,
        ST_CAPTURE,
        ST_HOLD
    } hms_state_e;
endpackage

// File: rtl/hms_block_buf.sv
module hms_block_buf #(
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        wr_en,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic                        wr_last,
    input  logic                        drain,
    input  logic                        seed,
    output logic [BLK_WORDS*WORD_W-1:0] block_o,
    output logic                        full_o
);
    localparam int CW = $clog2(BLK_WORDS);

    logic [WORD_W-1:0] slot [BLK_WORDS];
    logic [CW-1:0]     cnt;

    assign full_o = (cnt == CW'(BLK_WORDS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < BLK_WORDS; i++) slot[i] <= '0;
        end else if (clr || drain) begin
            cnt <= '0;
            for (int i = 0; i < BLK_WORDS; i++) slot[i] <= '0;
            if (!clr && seed) slot[0] <= WORD_W'(1);
        end else if (wr_en) begin
            slot[cnt] <= wr_data;
            if (wr_last && !full_o) slot[cnt + CW'(1)] <= WORD_W'(1);
            cnt <= full_o ? '0 : cnt + CW'(1);
        end
    end

    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_flat
        assign block_o[g*WORD_W +: WORD_W] = slot[g];
    end
endmodule

// File: rtl/hms_step_ctr.sv
module hms_step_ctr #(
    parameter int COUNT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last_o
);
    localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic [CW-1:0] cnt;

    assign last_o = (cnt == CW'(COUNT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/hms_fsm.sv
module hms_fsm
    import hms_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    input  logic in_last,
    input  logic blk_full,
    input  logic pull_last,
    output logic in_ready,
    output logic core_step,
    output logic core_pull,
    output logic buf_wr,
    output logic buf_drain,
    output logic buf_seed,
    output logic pctr_clr,
    output logic pctr_inc,
    output logic cap_en
);
    hms_state_e state, nxt;
    logic       closing;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            closing <= 1'b0;
        end else begin
            state <= nxt;
            if (start)                         closing <= 1'b0;
            else if (buf_wr && blk_full)       closing <= in_last;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    nxt = ST_IDLE;
            ST_FILL:    if (in_valid) begin
                            if (blk_full)     nxt = ST_PUSH;
                            else if (in_last) nxt = ST_FINAL;
                        end
            ST_PUSH:    nxt = closing ? ST_FINAL : ST_FILL;
            ST_FINAL:   nxt = ST_PULL;
            ST_PULL:    if (pull_last) nxt = ST_CAPTURE;
            ST_CAPTURE: nxt = ST_HOLD;
            ST_HOLD:    nxt = ST_HOLD;
            default:    nxt = ST_IDLE;
        endcase
        if (start) nxt = ST_FILL;
    end

    always_comb begin
        in_ready  = (state == ST_FILL) && !start;
        buf_wr    = in_ready && in_valid;
        core_step = !start && (state inside {ST_PUSH, ST_FINAL, ST_PULL});
        core_pull = !start && (state == ST_PULL);
        buf_drain = (state == ST_PUSH) || (state == ST_FINAL);
        buf_seed  = (state == ST_PUSH) && closing;
        pctr_clr  = (state == ST_FINAL);
        pctr_inc  = (state == ST_PULL);
        cap_en    = (state == ST_CAPTURE) && !start;
    end
endmodule

// File: rtl/hash_msg_sequencer.sv
module hash_msg_sequencer #(
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 8,
    parameter int PULLS     = 32,
    parameter int DIG_WORDS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [WORD_W-1:0]           in_data,
    input  logic                        in_last,
    output logic                        core_clear,
    output logic                        core_step,
    output logic                        core_pull,
    output logic [BLK_WORDS*WORD_W-1:0] core_block,
    input  logic [DIG_WORDS*WORD_W-1:0] core_state_hi,
    output logic [DIG_WORDS*WORD_W-1:0] digest,
    output logic                        done
);
    logic blk_full, pull_last, buf_wr, buf_drain, buf_seed;
    logic pctr_clr, pctr_inc, cap_en;

    assign core_clear = start;

    hms_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_last(in_last), .blk_full(blk_full), .pull_last(pull_last),
        .in_ready(in_ready), .core_step(core_step), .core_pull(core_pull),
        .buf_wr(buf_wr), .buf_drain(buf_drain), .buf_seed(buf_seed),
        .pctr_clr(pctr_clr), .pctr_inc(pctr_inc), .cap_en(cap_en)
    );

    hms_block_buf #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(start), .wr_en(buf_wr),
        .wr_data(in_data), .wr_last(in_last), .drain(buf_drain),
        .seed(buf_seed), .block_o(core_block), .full_o(blk_full)
    );

    hms_step_ctr #(.COUNT(PULLS)) u_pctr (
        .clk(clk), .rst_n(rst_n), .clr(pctr_clr || start), .inc(pctr_inc),
        .last_o(pull_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            digest <= '0;
            done   <= 1'b0;
        end else begin
            done <= cap_en;
            if (start)       digest <= '0;
            else if (cap_en) digest <= core_state_hi;
        end
    end
endmodule

// File: rtl/hms_checker.sv
module hms_checker #(
    parameter int DW = 256
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          in_ready,
    input logic          core_clear,
    input logic          core_step,
    input logic          core_pull,
    input logic          done,
    input logic [DW-1:0] digest
);
    AST_STEP_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        core_step |-> !in_ready); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DIGEST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (done || $stable(digest))); // R9
    AST_PULL_IS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        core_pull |-> core_step); // R6
    AST_CLEAR_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        core_clear |-> !core_step); // R2
    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (in_ready || start)); // R2
endmodule

bind hash_msg_sequencer hms_checker #(.DW(DIG_WORDS*WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
    .core_clear(core_clear), .core_step(core_step), .core_pull(core_pull),
    .done(done), .digest(digest)
);

// File: tb/hash_msg_sequencer_bench.sv
`timescale 1ns/1ps
module hash_msg_sequencer_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
    logic [31:0]  in_data = '0;
    logic         in_ready, core_clear, core_step, core_pull, done;
    logic [255:0] core_block, core_state_hi, digest;

    always #2.5 clk = ~clk;

    hash_msg_sequencer u_hash_msg_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .core_clear(core_clear), .core_step(core_step), .core_pull(core_pull),
        .core_block(core_block), .core_state_hi(core_state_hi),
        .digest(digest), .done(done)
    );

    // each entry: {message length, expected push count}
    localparam logic [15:0] VEC [8] = '{
        {8'd1, 8'd1}, {8'd3, 8'd1}, {8'd7, 8'd1}, {8'd8, 8'd2},
        {8'd9, 8'd2}, {8'd16, 8'd3}, {8'd17, 8'd3}, {8'd23, 8'd3}
    };

    int n_chk = 0, n_bad = 0, cyc = 0;
    int push_seen = 0, pull_seen = 0, done_seen = 0, busy_ready = 0;
    int cur_len = 0;
    logic [7:0] cur_tag = '0;
    logic mon_on = 1'b0;

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input logic [7:0] tag, input int i);
        return {tag, 8'hC3, 16'(i)};
    endfunction

    function automatic logic [255:0] exp_block(input int len, input logic [7:0] tag,
                                               input int k);
        logic [255:0] b = '0;
        for (int j = 0; j < 8; j++) begin
            int idx = 8 * k + j;
            if (idx < len)       b[32*j +: 32] = word(tag, idx);
            else if (idx == len) b[32*j +: 32] = 32'd1;
        end
        return b;
    endfunction

    function automatic logic [255:0] state_pat(input logic [7:0] tag);
        logic [255:0] s;
        for (int j = 0; j < 8; j++) s[32*j +: 32] = {8'hD0 ^ tag, 16'h0, 8'(9 + j)};
        return s;
    endfunction

    // monitor: sample a little after the falling edge
    always begin
        @(negedge clk); #1;
        if (rst_n && mon_on) begin
            if (core_step && !core_pull) begin
                // R3 R4 R5 block content and padding
                check(core_block == exp_block(cur_len, cur_tag, push_seen),
                      (cur_len % 8 == 0 && push_seen == cur_len / 8) ? "R5" :
                      (push_seen == cur_len / 8) ? "R4" : "R3",
                      core_block, exp_block(cur_len, cur_tag, push_seen));
                check(pull_seen == 0, "R6", 256'(pull_seen), 256'd0);
                push_seen++;
            end
            if (core_step && core_pull) pull_seen++;
            if (core_step && in_ready) busy_ready++;
            if (done) done_seen++;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    task automatic pulse_start(input int len, input logic [7:0] tag);
        @(negedge clk);
        start = 1'b1;
        #1;
        check(core_clear == 1'b1 && core_step == 1'b0, "R2",
              256'({core_clear, core_step}), 256'b10);
        @(negedge clk);
        start = 1'b0;
        cur_len = len; cur_tag = tag;
        push_seen = 0; pull_seen = 0; done_seen = 0; busy_ready = 0;
        core_state_hi = state_pat(tag);
        mon_on = 1'b1;
        #1;
        check(in_ready == 1'b1, "R2", 256'(in_ready), 256'd1);
        check(digest == '0, "R9", digest, 256'd0);
    endtask

    task automatic send(input int len, input logic [7:0] tag, input bit with_last);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = word(tag, i);
            in_last  = with_last && (i == len - 1);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    endtask

    task automatic finish_msg(input int exp_push);
        logic [255:0] held;
        int w = 0;
        while (done_seen == 0 && w < 500) begin @(negedge clk); #2; w++; end
        check(done_seen == 1, "R7", 256'(done_seen), 256'd1);
        check(digest == state_pat(cur_tag), "R7", digest, state_pat(cur_tag));
        check(push_seen == exp_push, "R3", 256'(push_seen), 256'(exp_push));
        check(pull_seen == 32, "R6", 256'(pull_seen), 256'd32);
        check(busy_ready == 0, "R8", 256'(busy_ready), 256'd0);
        held = digest;
        // offer words while held; none may be taken
        @(negedge clk);
        in_valid = 1'b1; in_data = 32'hDEAD_BEEF; in_last = 1'b1;
        core_state_hi = ~core_state_hi;
        repeat (4) begin
            @(negedge clk); #1;
            check(in_ready == 1'b0 && core_step == 1'b0, "R8",
                  256'({in_ready, core_step}), 256'd0);
        end
        in_valid = 1'b0; in_last = 1'b0;
        check(done == 1'b0 && done_seen == 1, "R7", 256'(done_seen), 256'd1);
        check(digest == held, "R9", digest, held);
        mon_on = 1'b0;
    endtask

    initial begin
        core_state_hi = '0;
        repeat (3) @(negedge clk);
        #1;
        check(in_ready == 0 && core_step == 0 && core_pull == 0 && done == 0,
              "R1", 256'({in_ready, core_step, core_pull, done}), 256'd0);
        check(digest == '0, "R1", digest, 256'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(in_ready == 0 && core_step == 0 && done == 0, "R1",
              256'({in_ready, core_step, done}), 256'd0);

        for (int v = 0; v < 8; v++) begin
            pulse_start(int'(VEC[v][15:8]), 8'(v + 1));
            send(int'(VEC[v][15:8]), 8'(v + 1), 1'b1);
            finish_msg(int'(VEC[v][7:0]));
        end

        // R2: start in the middle of a message discards partial words
        pulse_start(0, 8'h77);
        send(3, 8'h77, 1'b0);
        pulse_start(2, 8'h42);
        send(2, 8'h42, 1'b1);
        finish_msg(1);

        // R5: boundary again after a multi-block message, different tag
        pulse_start(24, 8'h99);
        send(24, 8'h99, 1'b1);
        finish_msg(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule